// File: doc/BRIEF.md
# Programmable Time-Constant Baud Clock Generator

This block produces the bit-rate timing for one serial channel. A down-counter is loaded from a 16-bit time constant (TC). The baud clock output changes level each time the counter expires. The full baud period is therefore 2×(TC+2) system clocks. TC = 0 is a legal value and gives the fastest rate. The transmitter and the receiver of a channel both take their timing from this single counter.

A second stage counts rising edges of the baud clock and divides them by 16, 32 or 64 to form a one-cycle bit strobe. The time constant is written one byte at a time through a small register write port: register 12 holds the low byte and register 13 holds the high byte. With a 7.3728 MHz system clock in ×16 mode, TC values 22, 10, 4 and 0 give 9600, 19200, 38400 and 115200 baud.

Top module: `tc_baud_gen`

## Requirements
- R1: After reset, baud_tgl and bit_stb are 0, the time constant is 0 and the divide ratio is ×16. If the generator is then enabled without any writes, the first bit_stb comes 62 clocks after enable, and later ones come every 64 clocks.
- R2: A write with wr_en=1 to register 12 loads wr_data into TC bits 7:0. A write to register 13 loads wr_data into TC bits 15:8. Each write changes only its own byte.
- R3: A write to any register other than 12 or 13 has no effect on the time constant. So does any cycle with wr_en=0, whatever the address and data.
- R4: While gen_en=1, baud_tgl changes level once every TC+2 clocks. The first rise of baud_tgl is TC+2 clocks after gen_en is raised.
- R5: clk_mode encodings are: 0 gives ×16, 1 gives ×32, and 2 or 3 give ×64. bit_stb is a one-clock pulse. It is raised in the same clock as every N-th rise of baud_tgl, where N is the selected ratio.
- R6: clk_mode is sampled only while gen_en=0. A change made while the generator runs has no effect until the generator has been disabled and enabled again.
- R7: While gen_en=0, baud_tgl is held low and bit_stb stays 0. The down-counter sits at its reload value and the edge divider is cleared, so a restart begins a fresh cycle.
- R8: A time constant written while the generator runs takes effect at the next reload. The half-period already in progress finishes with the old value.
- R9: The high byte takes part in the count. For example, TC = 0x0102 gives a 260-clock half-period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register number of the write |
| wr_data | input | 8 | Byte to write |
| gen_en | input | 1 | Generator enable |
| clk_mode | input | 2 | Divide ratio select (0: ×16, 1: ×32, 2/3: ×64) |
| baud_tgl | output | 1 | Baud clock, toggles every TC+2 clocks |
| bit_stb | output | 1 | One-clock bit-sample strobe |

## Verification
A wrong counter reload or a wrong comparison changes the spacing of baud_tgl edges. That error shows up at the first level change, at most TC+2 clocks after enable. Faults in the edge divider or in the mode latch only show up at bit_stb, up to 64 baud periods later. For that reason the strobe distance is measured from enable and also between two successive strobes. A mis-steered byte write looks correct until the next reload, so each write is followed by a full edge-distance measurement.

// File: rtl/tc_baud_pkg.sv
package tc_baud_pkg;

    typedef enum logic [1:0] {
        DIV_X16  = 2'd0,
        DIV_X32  = 2'd1,
        DIV_X64  = 2'd2,
        DIV_X64B = 2'd3
    } div_mode_e;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/tc_reg_bank.sv
module tc_reg_bank #(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned TC_W     = 16,
    parameter int unsigned BASE_IDX = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [tc_baud_pkg::BYTE_W-1:0] wr_data,
    output logic [TC_W-1:0]               tc_o
);
    localparam int unsigned NBYTES = TC_W / tc_baud_pkg::BYTE_W;

    typedef struct packed {
        logic [TC_W-1:0] tc;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < NBYTES; b++) begin
            if (wr_en && (wr_addr == ADDR_W'(BASE_IDX + b))) begin
                st_d.tc[b*tc_baud_pkg::BYTE_W +: tc_baud_pkg::BYTE_W] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tc_o = st_q.tc;
endmodule

// File: rtl/tc_down_counter.sv
module tc_down_counter #(
    parameter int unsigned TC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic [TC_W-1:0] tc_i,
    output logic            baud_o,
    output logic            rise_o
);
    localparam int unsigned CNT_W = TC_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             baud;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic [CNT_W-1:0] reload;

    always_comb begin
        reload = CNT_W'(tc_i) + CNT_W'(1);
        st_d   = st_q;
        rise_o = 1'b0;
        if (!en_i) begin
            st_d.cnt  = reload;
            st_d.baud = 1'b0;
        end else if (st_q.cnt == '0) begin
            st_d.cnt  = reload;
            st_d.baud = ~st_q.baud;
            rise_o    = ~st_q.baud;
        end else begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= CNT_W'(1);
            st_q.baud <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign baud_o = st_q.baud;
endmodule

// File: rtl/tc_edge_divider.sv
module tc_edge_divider #(
    parameter int unsigned BASE_DIV = 16,
    parameter int unsigned STEPS    = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_i,
    input  logic                    rise_i,
    input  tc_baud_pkg::div_mode_e  mode_i,
    output logic                    stb_o
);
    import tc_baud_pkg::*;

    localparam int unsigned MAX_DIV = BASE_DIV << (STEPS - 1);
    localparam int unsigned PRE_W   = $clog2(MAX_DIV);

    typedef struct packed {
        div_mode_e        mode;
        logic [PRE_W-1:0] pre;
        logic             stb;
    } div_st_t;

    div_st_t          st_d, st_q;
    logic [PRE_W-1:0] last;

    always_comb begin
        int unsigned sel;
        sel  = (int'(st_q.mode) > int'(STEPS - 1)) ? STEPS - 1 : int'(st_q.mode);
        last = PRE_W'((BASE_DIV << sel) - 1);
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (!en_i) begin
            st_d.pre  = '0;
            st_d.mode = mode_i;
        end else if (rise_i) begin
            if (st_q.pre == last) begin
                st_d.pre = '0;
                st_d.stb = 1'b1;
            end else begin
                st_d.pre = st_q.pre + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= DIV_X16;
            st_q.pre  <= '0;
            st_q.stb  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stb_o = st_q.stb;
endmodule

// File: rtl/tc_baud_gen.sv
module tc_baud_gen #(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned TC_W     = 16,
    parameter int unsigned BASE_IDX = 12,
    parameter int unsigned BASE_DIV = 16,
    parameter int unsigned STEPS    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              gen_en,
    input  logic [1:0]        clk_mode,
    output logic              baud_tgl,
    output logic              bit_stb
);
    import tc_baud_pkg::*;

    logic [TC_W-1:0] tc_val;
    logic            baud_rise;
    div_mode_e       mode_sel;

    assign mode_sel = div_mode_e'(clk_mode);

    tc_reg_bank #(.ADDR_W(ADDR_W), .TC_W(TC_W), .BASE_IDX(BASE_IDX)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tc_o(tc_val)
    );

    tc_down_counter #(.TC_W(TC_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en_i(gen_en), .tc_i(tc_val),
        .baud_o(baud_tgl), .rise_o(baud_rise)
    );

    tc_edge_divider #(.BASE_DIV(BASE_DIV), .STEPS(STEPS)) u_div (
        .clk(clk), .rst_n(rst_n), .en_i(gen_en), .rise_i(baud_rise),
        .mode_i(mode_sel), .stb_o(bit_stb)
    );
endmodule

// File: rtl/tc_baud_checker.sv
module tc_baud_checker #(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned TC_W     = 16,
    parameter int unsigned BASE_IDX = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gen_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              baud_tgl,
    input logic              bit_stb,
    input logic [TC_W-1:0]   tc_val
);
    logic foreign_addr;
    assign foreign_addr = (wr_addr != ADDR_W'(BASE_IDX)) && (wr_addr != ADDR_W'(BASE_IDX + 1));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> (!baud_tgl && !bit_stb));

    assert_stb_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |-> $rose(baud_tgl));

    assert_min_half_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(baud_tgl) && gen_en) |=> baud_tgl);

    assert_foreign_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || foreign_addr) |=> $stable(tc_val));
endmodule

bind tc_baud_gen tc_baud_checker #(.ADDR_W(ADDR_W), .TC_W(TC_W), .BASE_IDX(BASE_IDX)) u_chk (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .baud_tgl(baud_tgl), .bit_stb(bit_stb), .tc_val(tc_val)
);

// File: tb/tb_tc_baud_gen.sv
module tb_tc_baud_gen;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       gen_en = 1'b0;
    logic [1:0] clk_mode = 2'd0;
    logic       baud_tgl, bit_stb;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tc_baud_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .gen_en(gen_en), .clk_mode(clk_mode),
        .baud_tgl(baud_tgl), .bit_stb(bit_stb)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic stop_gen();
        gen_en = 1'b0;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic start_gen();
        @(negedge clk);
        gen_en = 1'b1;
    endtask

    // counts negedges until baud_tgl reaches level lv
    task automatic wait_level(input logic lv, output int n);
        n = 0;
        do begin
            @(negedge clk);
            wr_en = 1'b0;
            n++;
        end while (baud_tgl !== lv && n < 20000);
    endtask

    task automatic wait_stb(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (bit_stb !== 1'b1 && n < 20000);
    endtask

    task automatic set_tc(input int v);
        stop_gen();
        reg_write(4'd12, v[7:0]);
        reg_write(4'd13, v[15:8]);
    endtask

    task automatic t_reset();
        int n;
        chk(baud_tgl === 1'b0 && bit_stb === 1'b0, "R1 reset outputs", int'(baud_tgl), 0);
        start_gen();
        wait_stb(n);
        chk(n == 62, "R1 default first strobe (TC 0, x16)", n, 62);
        @(negedge clk);
        chk(bit_stb === 1'b0, "R5 strobe width one clock", int'(bit_stb), 0);
        wait_stb(n);
        chk(n == 63, "R5 x16 strobe spacing (after one-clock width)", n + 1, 64);
    endtask

    task automatic t_period();
        int n;
        set_tc(10);
        start_gen();
        wait_level(1'b1, n); chk(n == 12, "R4 first rise TC=10", n, 12);
        wait_level(1'b0, n); chk(n == 12, "R4 fall TC=10", n, 12);
        wait_level(1'b1, n); chk(n == 12, "R4 rise TC=10", n, 12);
        set_tc(16'h0102);
        start_gen();
        wait_level(1'b1, n); chk(n == 260, "R2 R9 high byte TC=0x0102", n, 260);
    endtask

    task automatic t_ignore();
        int n;
        set_tc(4);
        reg_write(4'd5, 8'hFF);
        reg_write(4'd14, 8'h33);
        wr_addr = 4'd12; wr_data = 8'h77; wr_en = 1'b0;
        @(negedge clk);
        start_gen();
        wait_level(1'b1, n); chk(n == 6, "R3 foreign writes ignored", n, 6);
        wait_level(1'b0, n); chk(n == 6, "R3 half period unchanged", n, 6);
    endtask

    task automatic t_modes();
        int n;
        set_tc(0);
        clk_mode = 2'd1;
        start_gen();
        wait_stb(n); chk(n == 126, "R5 x32 first strobe", n, 126);
        wait_stb(n); chk(n == 128, "R5 x32 spacing", n, 128);
        stop_gen();
        clk_mode = 2'd3;
        start_gen();
        wait_stb(n); chk(n == 254, "R5 mode 3 is x64", n, 254);
        stop_gen();
        clk_mode = 2'd2;
        start_gen();
        wait_stb(n); chk(n == 254, "R5 mode 2 is x64", n, 254);
    endtask

    task automatic t_mode_lock();
        int n;
        stop_gen();
        clk_mode = 2'd0;
        start_gen();
        @(negedge clk);
        clk_mode = 2'd2;
        wait_stb(n); chk(n + 1 == 62, "R6 mode change ignored while running", n + 1, 62);
        wait_stb(n); chk(n == 64, "R6 spacing stays x16", n, 64);
        stop_gen();
        start_gen();
        wait_stb(n); chk(n == 254, "R6 new mode after restart", n, 254);
        clk_mode = 2'd0;
    endtask

    task automatic t_disable();
        int n;
        int seen;
        set_tc(3);
        start_gen();
        wait_level(1'b1, n);
        gen_en = 1'b0;
        @(negedge clk);
        chk(baud_tgl === 1'b0, "R7 baud low when disabled", int'(baud_tgl), 0);
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (baud_tgl !== 1'b0 || bit_stb !== 1'b0) seen++;
        end
        chk(seen == 0, "R7 no activity while disabled", seen, 0);
        start_gen();
        wait_level(1'b1, n); chk(n == 5, "R7 restart fresh count", n, 5);
    endtask

    task automatic t_tc_change();
        int n;
        set_tc(10);
        start_gen();
        wait_level(1'b1, n);
        wr_en = 1'b1; wr_addr = 4'd12; wr_data = 8'd4;
        wait_level(1'b0, n); chk(n == 12, "R8 current half keeps old TC", n, 12);
        wait_level(1'b1, n); chk(n == 6, "R8 new TC at next reload", n, 6);
        stop_gen();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_period();
        t_ignore();
        t_modes();
        t_mode_lock();
        t_disable();
        t_tc_change();
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end
endmodule